// File: doc/BRIEF.md
# Reference Input Selection Controller

This block decides which of two reference clock inputs drives the downstream loop. A two-bit mode code picks manual selection, automatic non-revertive selection or automatic revertive selection. In manual mode a shared select pin is read as an input and names the active reference. In the two automatic modes the same pin is turned around and driven with the index of the active reference. Per-input fault flags, produced elsewhere, steer the automatic choice.

Input 1 (index 0) has priority. When the active input faults and the other is healthy, the block fails over. In revertive mode it returns to input 1 once that input has stayed fault-free for a programmable number of cycles. In non-revertive mode it stays on input 2 until input 2 faults. If both inputs are faulted, the selection is frozen and a holdover flag is raised.

Every change of the active index produces a one-cycle strobe for the phase build-out logic. If a switch happens while the two references are flagged as differing in frequency, a relock window output is held high for a programmable time, because the loop may lose lock briefly.

Top module: `ref_sel_ctrl`

## Requirements
- R1: After reset, act_o is 0 and switch_o, relock_o and holdover_o are 0.
- R2: With mode_i = 2'b00 (manual), act_o takes the value of sel_pin_i one clock later (0 selects input 1, 1 selects input 2). fault_i is ignored and sel_pin_oe_o is 0.
- R3: With mode_i other than 2'b00, sel_pin_oe_o is 1 and sel_pin_o equals act_o (0 for input 1, 1 for input 2).
- R4: In an automatic mode, if the active input's fault flag is set and the other input's flag is clear, act_o changes to the other input on the next clock. fault_i[0] belongs to input 1 and fault_i[1] to input 2.
- R5: With mode_i = 2'b01 (non-revertive), act_o stays 1 while fault_i[1] is clear, whatever the state of input 1.
- R6: With mode_i = 2'b10 or 2'b11 (revertive), act_o returns from 1 to 0 at the (QUAL_CNT+1)-th clock edge of an unbroken run in which fault_i[0] is sampled clear and fault_i[1] stays clear. Any sampled fault on input 1 restarts the count.
- R7: In an automatic mode with both fault flags set, holdover_o is 1 in the same cycle and act_o does not change.
- R8: switch_o is 1 for exactly the cycle in which act_o holds a new value, and 0 otherwise.
- R9: A switch made while freq_mis_i is 1 drives relock_o high for RELOCK_CYC cycles, starting with the switch cycle. A switch made with freq_mis_i at 0 does not raise relock_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 manual, 01 auto non-revertive, 10/11 auto revertive |
| sel_pin_i | input | 1 | Select pin input value (manual mode) |
| fault_i | input | 2 | Fault flags; bit 0 input 1, bit 1 input 2 |
| freq_mis_i | input | 1 | Inputs differ in frequency beyond the lock tolerance |
| act_o | output | 1 | Active input index (0 input 1, 1 input 2) |
| sel_pin_o | output | 1 | Select pin drive (active indicator) |
| sel_pin_oe_o | output | 1 | Select pin output enable |
| switch_o | output | 1 | One-cycle strobe on a change of the active input |
| holdover_o | output | 1 | Both inputs faulted in an automatic mode |
| relock_o | output | 1 | Relock window after a mismatched switch |

## Verification
The bench times the revertive return to the exact edge. A qualifier that is off by one returns one cycle early or late, and one that never clears on a fault returns to a faulty input. It confirms that non-revertive mode ignores a recovered input 1, and that manual mode ignores faults, which a mode decode that leaks the automatic logic would fail. It freezes both inputs to check holdover, where a careless priority chain would flip to a faulted input. It also counts the exact length of the relock window, and checks that a matched switch leaves the window closed.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;
  localparam logic [1:0] MODE_MAN     = 2'b00;
  localparam logic [1:0] MODE_AUTO_NR = 2'b01;

  function automatic logic mode_is_auto(input logic [1:0] m);
    return m != MODE_MAN;
  endfunction

  function automatic logic mode_is_rev(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/ref_sel_qual.sv
module ref_sel_qual #(
  parameter int QUAL_CNT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_i,
  output logic done_o
);
  localparam int W = $clog2(QUAL_CNT + 1);
  localparam logic [W-1:0] QMAX = W'(QUAL_CNT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (fault_i)      cnt_q <= '0;
    else if (cnt_q != QMAX) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == QMAX);

  a_r6_qual_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> !done_o);
  a_r6_qual_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fault_i |=> done_o);
endmodule

// File: rtl/ref_sel_relock.sv
module ref_sel_relock #(
  parameter int RELOCK_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int W = $clog2(RELOCK_CYC + 1);
  localparam logic [W-1:0] RMAX = W'(RELOCK_CYC);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= RMAX;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  a_r9_relock_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o);
  a_r9_relock_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !load_i |=> !busy_o);
endmodule

// File: rtl/ref_sel_ctrl.sv
module ref_sel_ctrl
  import ref_sel_pkg::*;
#(
  parameter int QUAL_CNT   = 16,
  parameter int RELOCK_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       sel_pin_i,
  input  logic [1:0] fault_i,
  input  logic       freq_mis_i,
  output logic       act_o,
  output logic       sel_pin_o,
  output logic       sel_pin_oe_o,
  output logic       switch_o,
  output logic       holdover_o,
  output logic       relock_o
);
  logic act_q, act_d, sw_q, qual_done, is_auto, is_rev, both_flt, change;

  assign is_auto  = mode_is_auto(mode_i);
  assign is_rev   = mode_is_rev(mode_i);
  assign both_flt = fault_i[0] & fault_i[1];

  ref_sel_qual #(.QUAL_CNT(QUAL_CNT)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fault_i(fault_i[0]),
    .done_o (qual_done)
  );

  // input 1 has priority; fail over only to a healthy input
  always_comb begin
    act_d = act_q;
    if (!is_auto)                                     act_d = sel_pin_i;
    else if (both_flt)                                act_d = act_q;
    else if (!act_q && fault_i[0])                    act_d = 1'b1;
    else if (act_q && fault_i[1])                     act_d = 1'b0;
    else if (act_q && is_rev && qual_done && !fault_i[0]) act_d = 1'b0;
  end

  assign change = (act_d != act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      sw_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      sw_q  <= change;
    end
  end

  ref_sel_relock #(.RELOCK_CYC(RELOCK_CYC)) u_relock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (change & freq_mis_i),
    .busy_o (relock_o)
  );

  assign act_o        = act_q;
  assign sel_pin_o    = act_q;
  assign sel_pin_oe_o = is_auto;
  assign switch_o     = sw_q;
  assign holdover_o   = is_auto & both_flt;

  a_r2_manual_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_MAN |=> act_o == $past(sel_pin_i));
  a_r4_failover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_auto && !act_o && fault_i[0] && !fault_i[1] |=> act_o);
  a_r5_nonrev_stay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_AUTO_NR && act_o && !fault_i[1] |=> act_o);
  a_r7_holdover_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    holdover_o |=> $stable(act_o));
  a_r8_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 (switch_o == (act_o != $past(act_o))));
endmodule

// File: tb/tb_ref_sel_ctrl.sv
module tb_ref_sel_ctrl;
  localparam int QC = 16;
  localparam int RC = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00, fault = 2'b00;
  logic sel = 1'b0, fmis = 1'b0;
  logic act, spo, spoe, sw, hold, rel;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ref_sel_ctrl #(.QUAL_CNT(QC), .RELOCK_CYC(RC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .sel_pin_i(sel),
    .fault_i(fault), .freq_mis_i(fmis), .act_o(act), .sel_pin_o(spo),
    .sel_pin_oe_o(spoe), .switch_o(sw), .holdover_o(hold), .relock_o(rel)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b exp %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic force_act(input logic v);
    mode = 2'b00; sel = v; fmis = 1'b0; fault = 2'b00;
    step(RC + 2);
  endtask

  task automatic t_reset;
    step(3); rst_n = 1'b1; step(1);
    chk("R1 act", act, 1'b0);
    chk("R1 switch", sw, 1'b0);
    chk("R1 relock", rel, 1'b0);
    chk("R1 holdover", hold, 1'b0);
  endtask

  task automatic t_manual;
    force_act(1'b0);
    fault = 2'b01; sel = 1'b1; step(1);
    chk("R2 sel1", act, 1'b1);
    chk("R2 oe", spoe, 1'b0);
    chk("R8 strobe on", sw, 1'b1);
    step(1);
    chk("R8 strobe off", sw, 1'b0);
    sel = 1'b0; step(1);
    chk("R2 fault ignored", act, 1'b0);
    chk("R2 no holdover", hold, 1'b0);
  endtask

  task automatic t_failover;
    force_act(1'b0);
    mode = 2'b01; #1;
    chk("R3 oe", spoe, 1'b1);
    chk("R3 pin in1", spo, 1'b0);
    fault = 2'b01; step(1);
    chk("R4 to in2", act, 1'b1);
    chk("R3 pin in2", spo, 1'b1);
    chk("R8 strobe", sw, 1'b1);
  endtask

  task automatic t_nonrev;
    force_act(1'b1);
    mode = 2'b01; fault = 2'b00; step(3 * QC);
    chk("R5 stays on in2", act, 1'b1);
    chk("R8 quiet", sw, 1'b0);
    fault = 2'b10; step(1);
    chk("R4 back to in1", act, 1'b0);
  endtask

  task automatic t_revert(input logic [1:0] m);
    force_act(1'b0);
    mode = m; fault = 2'b01; step(1);
    chk("R4 failover", act, 1'b1);
    fault = 2'b00; step(QC - 4);
    fault = 2'b01; step(1);
    fault = 2'b00; step(QC);
    chk("R6 not yet", act, 1'b1);
    step(1);
    chk("R6 reverted", act, 1'b0);
    chk("R8 strobe", sw, 1'b1);
  endtask

  task automatic t_holdover;
    force_act(1'b0);
    mode = 2'b10; fault = 2'b11; #1;
    chk("R7 flag", hold, 1'b1);
    step(3);
    chk("R7 held in1", act, 1'b0);
    fault = 2'b01; step(1);
    chk("R7 flag clear", hold, 1'b0);
    chk("R4 to in2", act, 1'b1);
    fault = 2'b11; step(QC + 4);
    chk("R7 held in2", act, 1'b1);
    chk("R7 flag", hold, 1'b1);
  endtask

  task automatic t_relock;
    force_act(1'b0);
    mode = 2'b01; fmis = 1'b1; fault = 2'b01; step(1);
    chk("R9 switch", act, 1'b1);
    chk("R9 on", rel, 1'b1);
    step(RC - 1);
    chk("R9 last", rel, 1'b1);
    step(1);
    chk("R9 off", rel, 1'b0);
    fmis = 1'b0; fault = 2'b10; step(1);
    chk("R9 matched switch", act, 1'b0);
    chk("R9 stays off", rel, 1'b0);
  endtask

  initial begin
    t_reset;
    t_manual;
    t_failover;
    t_nonrev;
    t_revert(2'b10);
    t_revert(2'b11);
    t_holdover;
    t_relock;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule